// File: doc/BRIEF.md
# UART Line Status Register

This block holds the eight status flags a CPU reads to follow a UART's receive and transmit activity. It does not shift serial data, count baud ticks or store characters. Those parts sit around it and report through level and strobe inputs. This block turns their reports into one readable status byte and a transmit-empty interrupt request.

The UART runs in one of two modes, chosen by `fifo_mode`:

- **Character mode:** a single receive buffer and a single transmit holding register. The receiver reports errors through one-cycle strobes.
- **FIFO mode:** receive and transmit queues. The receive queue reports the error tags of its head entry, and whether any errored entry is still stored anywhere in it.

The set and clear rules for several flags depend on the mode. This includes a queue-wide error summary bit that a status read clears only when no errored entries remain. All inputs and outputs are plain control and status pins. The block has no data stream and no handshake.

A status read is a one-cycle `cpu_lsr_rd` pulse. The byte on `lsr` during that cycle is the value the CPU sees. Flags that clear on read drop at the next clock edge.

Top module: `uart_lsr`

## Requirements
- R1: After reset, bits 1 to 5 and 7 of `lsr` and `thre_irq` take their idle values: bit 5 (transmit holding empty) is 1, and bits 1 to 4, bit 7 and `thre_irq` are 0. With both transmit empties high and no receive data, `lsr` reads 8'h60.
- R2: Bit 0 (receive data ready) follows a level input in the same cycle. It follows `rx_buf_full` in character mode and `rx_fifo_nempty` in FIFO mode. The input for the other mode has no effect.
- R3: Bits 1 (overrun), 2 (parity), 3 (framing) and 4 (break) are sticky.
  - Each bit sets at the clock edge after its event and then holds.
  - A `cpu_lsr_rd` pulse clears it at the next edge.
  - If an event and a read fall in the same cycle, the event wins and the bit stays 1.
- R4: In FIFO mode, bits 2, 3 and 4 set from the head-entry tags `head_par_tag`, `head_frm_tag` and `head_brk_tag`, and only while `rx_fifo_nempty` is 1. The character-mode strobes `rx_par_ev`, `rx_frm_ev` and `rx_brk_ev` have no effect in this mode. Bit 1 sets from `rx_ovr_ev` in both modes.
- R5: Bit 5 (transmit holding empty) sets at the edge after one of two causes, and a `cpu_tx_wr` pulse clears it at the next edge.
  - In character mode, the cause is a `tx_hold_load` strobe.
  - In FIFO mode, the cause is `tx_fifo_empty` rising from 0 to 1.
  - If a write coincides with a set cause, the write wins and bit 5 goes to 0.
- R6: Bit 6 (transmitter empty) is combinational. It is `tx_hold_empty & tx_shift_empty` in character mode and `tx_fifo_empty & tx_shift_empty` in FIFO mode.
- R7: In character mode, bit 7 reads 0 whatever `rx_fifo_err_any` does.
- R8: In FIFO mode, bit 7 sets at the edge after `rx_fifo_err_any` is 1, and holds while no read occurs. A read clears it at the next edge only if `rx_fifo_err_any` is 0 in the read cycle. Otherwise it stays 1.
- R9: `thre_irq` sets at the same edge where bit 5 goes from 0 to 1, if `thre_irq_en` is 1 in that cycle. A `cpu_tx_wr` pulse clears it at the next edge. A bit 5 rise with `thre_irq_en` at 0 leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_mode | input | 1 | 1 selects FIFO mode, 0 selects character mode |
| rx_buf_full | input | 1 | Character-mode receive buffer holds a character |
| rx_fifo_nempty | input | 1 | Receive queue is not empty |
| rx_ovr_ev | input | 1 | Overrun strobe from the receiver |
| rx_par_ev | input | 1 | Parity error strobe (character mode) |
| rx_frm_ev | input | 1 | Missing stop bit strobe (character mode) |
| rx_brk_ev | input | 1 | Break strobe (character mode) |
| head_par_tag | input | 1 | Head queue entry has a parity error |
| head_frm_tag | input | 1 | Head queue entry lacks a stop bit |
| head_brk_tag | input | 1 | Head queue entry is a break |
| rx_fifo_err_any | input | 1 | At least one errored entry is stored in the receive queue |
| tx_hold_load | input | 1 | Strobe: holding register moved its character into the shift register |
| tx_hold_empty | input | 1 | Transmit holding register is empty |
| tx_shift_empty | input | 1 | Transmit shift register is empty |
| tx_fifo_empty | input | 1 | Transmit queue is empty |
| cpu_tx_wr | input | 1 | CPU write of transmit data |
| cpu_lsr_rd | input | 1 | CPU read of the status byte |
| thre_irq_en | input | 1 | Transmit-empty interrupt enable |
| lsr | output | 8 | Status byte |
| thre_irq | output | 1 | Transmit-empty interrupt request |

## Verification
Bits 0 and 6 are combinational, so the bench checks them a couple of nanoseconds after changing the inputs, with no clock edge in between. Every other bit, and `thre_irq`, comes from one register stage. These results are due one edge after the causing cycle. Each task therefore drives its inputs just after a rising edge, waits for the next rising edge, and samples 2 ns after it, well before the falling edge. Same-cycle collisions are covered by driving both inputs in one cycle: event with read, and write with set cause. Error-summary retention is covered by issuing a read while errored entries remain.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;
  localparam int LSR_W      = 8;
  localparam int NUM_STICKY = 4;   // overrun, parity, framing, break
  // bit positions software decodes
  localparam int B_DR   = 0;
  localparam int B_OVR  = 1;
  localparam int B_PAR  = 2;
  localparam int B_FRM  = 3;
  localparam int B_BRK  = 4;
  localparam int B_THRE = 5;
  localparam int B_TEMT = 6;
  localparam int B_ESUM = 7;
  localparam int STK_LO = B_OVR;
  localparam int STK_HI = STK_LO + NUM_STICKY - 1;
endpackage

// File: rtl/lsr_sticky_flag.sv
module lsr_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  // R3: a set event is visible after the edge, even against a read
  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  // R3: read alone clears
  p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
  // R3: nothing changes without a set or a read
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/lsr_rx_status.sv
module lsr_rx_status
  import uart_lsr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fifo_mode,
  input  logic                  rx_buf_full,
  input  logic                  rx_fifo_nempty,
  input  logic [NUM_STICKY-1:0] char_ev,     // [0]=ovr [1]=par [2]=frm [3]=brk
  input  logic [NUM_STICKY-2:0] head_tag,    // [0]=par [1]=frm [2]=brk
  input  logic                  fifo_err_any,
  input  logic                  lsr_rd,
  output logic                  data_rdy,
  output logic [NUM_STICKY-1:0] sticky,
  output logic                  err_sum
);
  logic [NUM_STICKY-1:0] set_vec;

  assign data_rdy = fifo_mode ? rx_fifo_nempty : rx_buf_full;

  // overrun always comes from the receiver strobe
  assign set_vec[0] = char_ev[0];

  genvar gi;
  generate
    for (gi = 1; gi < NUM_STICKY; gi++) begin : g_err_src
      assign set_vec[gi] = fifo_mode ? (head_tag[gi-1] & rx_fifo_nempty)
                                     : char_ev[gi];
    end
    for (gi = 0; gi < NUM_STICKY; gi++) begin : g_flag
      lsr_sticky_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec[gi]),
        .clr_i  (lsr_rd),
        .flag_o (sticky[gi])
      );
    end
  endgenerate

  // queue-wide error summary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            err_sum <= 1'b0;
    else if (!fifo_mode)   err_sum <= 1'b0;
    else if (fifo_err_any) err_sum <= 1'b1;
    else if (lsr_rd)       err_sum <= 1'b0;
  end

  p_esum_char_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |=> !err_sum);
  p_esum_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && fifo_err_any) |=> err_sum);
  p_esum_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && err_sum && !lsr_rd) |=> err_sum);
  p_fifo_ignores_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && !rx_fifo_nempty && !lsr_rd) |=> $stable(sticky[NUM_STICKY-1:1]));
endmodule

// File: rtl/lsr_tx_status.sv
module lsr_tx_status (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_mode,
  input  logic hold_load,
  input  logic hold_empty,
  input  logic shift_empty,
  input  logic txq_empty,
  input  logic cpu_wr,
  input  logic irq_en,
  output logic thre,
  output logic temt,
  output logic irq
);
  logic txq_empty_q;
  logic txq_rise;
  logic thre_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) txq_empty_q <= 1'b1;
    else        txq_empty_q <= txq_empty;
  end

  assign txq_rise = txq_empty & ~txq_empty_q;
  assign thre_set = fifo_mode ? txq_rise : hold_load;
  assign temt     = shift_empty & (fifo_mode ? txq_empty : hold_empty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thre <= 1'b1;
      irq  <= 1'b0;
    end else if (cpu_wr) begin
      thre <= 1'b0;
      irq  <= 1'b0;
    end else if (thre_set) begin
      thre <= 1'b1;
      if (!thre && irq_en) irq <= 1'b1;
    end
  end

  p_wr_clears_thre_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |=> !thre);
  p_thre_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_wr && !hold_load && !txq_empty) |=> $stable(thre));
  p_irq_on_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($rose(thre) && $past(irq_en)));
  p_wr_clears_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |=> !irq);
endmodule

// File: rtl/uart_lsr.sv
module uart_lsr
  import uart_lsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_mode,
  input  logic             rx_buf_full,
  input  logic             rx_fifo_nempty,
  input  logic             rx_ovr_ev,
  input  logic             rx_par_ev,
  input  logic             rx_frm_ev,
  input  logic             rx_brk_ev,
  input  logic             head_par_tag,
  input  logic             head_frm_tag,
  input  logic             head_brk_tag,
  input  logic             rx_fifo_err_any,
  input  logic             tx_hold_load,
  input  logic             tx_hold_empty,
  input  logic             tx_shift_empty,
  input  logic             tx_fifo_empty,
  input  logic             cpu_tx_wr,
  input  logic             cpu_lsr_rd,
  input  logic             thre_irq_en,
  output logic [LSR_W-1:0] lsr,
  output logic             thre_irq
);
  logic                  data_rdy;
  logic [NUM_STICKY-1:0] sticky;
  logic                  err_sum;
  logic                  thre;
  logic                  temt;

  lsr_rx_status u_rx (
    .clk            (clk),
    .rst_n          (rst_n),
    .fifo_mode      (fifo_mode),
    .rx_buf_full    (rx_buf_full),
    .rx_fifo_nempty (rx_fifo_nempty),
    .char_ev        ({rx_brk_ev, rx_frm_ev, rx_par_ev, rx_ovr_ev}),
    .head_tag       ({head_brk_tag, head_frm_tag, head_par_tag}),
    .fifo_err_any   (rx_fifo_err_any),
    .lsr_rd         (cpu_lsr_rd),
    .data_rdy       (data_rdy),
    .sticky         (sticky),
    .err_sum        (err_sum)
  );

  lsr_tx_status u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_mode   (fifo_mode),
    .hold_load   (tx_hold_load),
    .hold_empty  (tx_hold_empty),
    .shift_empty (tx_shift_empty),
    .txq_empty   (tx_fifo_empty),
    .cpu_wr      (cpu_tx_wr),
    .irq_en      (thre_irq_en),
    .thre        (thre),
    .temt        (temt),
    .irq         (thre_irq)
  );

  always_comb begin
    lsr                 = '0;
    lsr[B_DR]           = data_rdy;
    lsr[STK_HI:STK_LO]  = sticky;
    lsr[B_THRE]         = thre;
    lsr[B_TEMT]         = temt;
    lsr[B_ESUM]         = err_sum;
  end

  // R6: transmitter-empty implies the shift register is idle
  p_temt_needs_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[B_TEMT] |-> tx_shift_empty);
  // R1: interrupt request only alongside an empty holding flag or write pending
  p_irq_with_thre_r1: assert property (@(posedge clk) disable iff (!rst_n)
    thre_irq |-> lsr[B_THRE]);
endmodule

// File: tb/uart_lsr_tb_top.sv
module uart_lsr_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_mode = 0, rx_buf_full = 0, rx_fifo_nempty = 0;
  logic rx_ovr_ev = 0, rx_par_ev = 0, rx_frm_ev = 0, rx_brk_ev = 0;
  logic head_par_tag = 0, head_frm_tag = 0, head_brk_tag = 0, rx_fifo_err_any = 0;
  logic tx_hold_load = 0, tx_hold_empty = 1, tx_shift_empty = 1, tx_fifo_empty = 1;
  logic cpu_tx_wr = 0, cpu_lsr_rd = 0, thre_irq_en = 0;
  logic [7:0] lsr;
  logic thre_irq;
  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;   // 50 MHz

  uart_lsr dut_i (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FIFO-free FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // wait one rising edge, sample 2 ns after it
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    check("R1 reset lsr", lsr, 8'h60);
    check("R1 reset irq", {7'b0, thre_irq}, 8'h00);
  endtask

  task automatic t_ready();
    fifo_mode = 0; rx_buf_full = 1; #2;
    check("R2 char-mode ready", {7'b0, lsr[0]}, 8'h01);
    rx_buf_full = 0; rx_fifo_nempty = 1; #2;
    check("R2 char-mode ignores queue flag", {7'b0, lsr[0]}, 8'h00);
    fifo_mode = 1; #2;
    check("R2 fifo-mode ready", {7'b0, lsr[0]}, 8'h01);
    rx_fifo_nempty = 0; rx_buf_full = 1; #2;
    check("R2 fifo-mode ignores buffer flag", {7'b0, lsr[0]}, 8'h00);
    rx_buf_full = 0; fifo_mode = 0;
    tick();
  endtask

  task automatic t_sticky();
    rx_par_ev = 1; rx_ovr_ev = 1; tick();
    rx_par_ev = 0; rx_ovr_ev = 0;
    check("R3 parity+overrun set", {4'b0, lsr[4:1]}, 8'h03);
    tick();
    check("R3 held", {4'b0, lsr[4:1]}, 8'h03);
    cpu_lsr_rd = 1; rx_frm_ev = 1; tick();
    cpu_lsr_rd = 0; rx_frm_ev = 0;
    check("R3 read clears, coincident framing wins", {4'b0, lsr[4:1]}, 8'h04);
    rx_brk_ev = 1; tick(); rx_brk_ev = 0;
    check("R3 break set", {4'b0, lsr[4:1]}, 8'h0C);
    cpu_lsr_rd = 1; tick(); cpu_lsr_rd = 0;
    check("R3 read clears all", {4'b0, lsr[4:1]}, 8'h00);
  endtask

  task automatic t_fifo_tags();
    fifo_mode = 1;
    rx_par_ev = 1; rx_frm_ev = 1; rx_brk_ev = 1; tick();
    rx_par_ev = 0; rx_frm_ev = 0; rx_brk_ev = 0;
    check("R4 strobes ignored in fifo mode", {4'b0, lsr[4:1]}, 8'h00);
    head_brk_tag = 1; tick();
    check("R4 tag with empty queue ignored", {4'b0, lsr[4:1]}, 8'h00);
    rx_fifo_nempty = 1; tick();
    head_brk_tag = 0; rx_fifo_nempty = 0;
    check("R4 head break tag", {4'b0, lsr[4:1]}, 8'h08);
    rx_ovr_ev = 1; tick(); rx_ovr_ev = 0;
    check("R4 overrun in fifo mode", {4'b0, lsr[4:1]}, 8'h09);
    cpu_lsr_rd = 1; tick(); cpu_lsr_rd = 0;
    fifo_mode = 0; tick();
  endtask

  task automatic t_thre_char();
    thre_irq_en = 1;
    cpu_tx_wr = 1; tx_hold_empty = 0; tick(); cpu_tx_wr = 0;
    check("R5 write clears thre", {7'b0, lsr[5]}, 8'h00);
    check("R6 temt low with full holding", {7'b0, lsr[6]}, 8'h00);
    tx_hold_load = 1; tx_hold_empty = 1; tx_shift_empty = 0; tick(); tx_hold_load = 0;
    check("R5 hold load sets thre", {7'b0, lsr[5]}, 8'h01);
    check("R9 irq raised", {7'b0, thre_irq}, 8'h01);
    check("R6 temt low while shifting", {7'b0, lsr[6]}, 8'h00);
    tx_shift_empty = 1; #2;
    check("R6 temt high", {7'b0, lsr[6]}, 8'h01);
    cpu_tx_wr = 1; tx_hold_load = 1; tick(); cpu_tx_wr = 0; tx_hold_load = 0;
    check("R5 write wins over load", {7'b0, lsr[5]}, 8'h00);
    check("R9 write clears irq", {7'b0, thre_irq}, 8'h00);
    thre_irq_en = 0; tx_hold_load = 1; tick(); tx_hold_load = 0;
    check("R9 disabled irq stays low", {7'b0, thre_irq}, 8'h00);
    check("R5 set with irq disabled", {7'b0, lsr[5]}, 8'h01);
  endtask

  task automatic t_thre_fifo();
    fifo_mode = 1; thre_irq_en = 1;
    cpu_tx_wr = 1; tx_fifo_empty = 0; tick(); cpu_tx_wr = 0;
    check("R5 fifo write clears", {7'b0, lsr[5]}, 8'h00);
    check("R6 fifo temt low", {7'b0, lsr[6]}, 8'h00);
    tx_hold_load = 1; tick(); tx_hold_load = 0;
    check("R5 hold load ignored in fifo mode", {7'b0, lsr[5]}, 8'h00);
    tx_fifo_empty = 1; tick();
    check("R5 queue drained sets", {7'b0, lsr[5]}, 8'h01);
    check("R9 fifo irq", {7'b0, thre_irq}, 8'h01);
    check("R6 fifo temt high", {7'b0, lsr[6]}, 8'h01);
    cpu_tx_wr = 1; tick(); cpu_tx_wr = 0; thre_irq_en = 0;
    fifo_mode = 0;
  endtask

  task automatic t_err_sum();
    fifo_mode = 0; rx_fifo_err_any = 1; tick();
    check("R7 summary zero in char mode", {7'b0, lsr[7]}, 8'h00);
    fifo_mode = 1; tick(); rx_fifo_err_any = 0;
    check("R8 summary set", {7'b0, lsr[7]}, 8'h01);
    tick();
    check("R8 summary held", {7'b0, lsr[7]}, 8'h01);
    rx_fifo_err_any = 1; cpu_lsr_rd = 1; tick(); cpu_lsr_rd = 0;
    check("R8 read keeps summary with errors left", {7'b0, lsr[7]}, 8'h01);
    rx_fifo_err_any = 0; cpu_lsr_rd = 1; tick(); cpu_lsr_rd = 0;
    check("R8 read clears summary", {7'b0, lsr[7]}, 8'h00);
    fifo_mode = 0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    tick();
    t_reset();
    t_ready();
    t_sticky();
    t_fifo_tags();
    t_thre_char();
    t_thre_fifo();
    t_err_sum();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule